// File: doc/BRIEF.md
# Dual-Clock Ready-Flag FIFO

This block carries a stream of 18-bit words from one clock domain to another. It has 512 entries of storage. The producer writes on its own free-running clock and the consumer reads on a second one. The two clocks may be unrelated or identical, and every transfer happens on a rising edge of the clock that owns the port.

Each side sees one registered ready flag in its own domain. On the producer side, `wr_ready` says there is room for another word. On the consumer side, `rd_valid` says a fresh word sits in the output register. The read side works in first-word-fall-through style. A word that arrives in an empty FIFO appears on `rd_data` on the same edge that raises `rd_valid`, so the consumer never has to issue a read to fetch it. When the FIFO runs dry, `rd_valid` drops, but the output register keeps the last word it delivered.

Pointers cross between the domains in Gray code through two-flop synchronizers. The producer side also reports a half-full level, `wr_half`. Each domain has its own synchronous reset, and the two resets are meant to be asserted together.

Top module: `xclk_fifo`

## Requirements
- R1: Words leave through `rd_data` in exactly the order they were accepted on `wr_data`, with all 18 bits intact, while the two clocks run at unrelated periods.
- R2: With no reads, `wr_ready` stays high until 512 words are stored, including the word held in the output register. It is low on the cycle after the 512th accepted write, and it rises again once reads free space.
- R3: A write is accepted only on a `wr_clk` edge where `wr_en` and `wr_ready` are both high. Requests made while `wr_ready` is low add no word to the stream.
- R4: A read is taken only on a `rd_clk` edge where `rd_en` and `rd_valid` are both high. Requests made while `rd_valid` is low change neither `rd_data` nor which word comes out next.
- R5: When a word is written into an empty FIFO, `rd_data` already carries that word in the first `rd_clk` cycle in which `rd_valid` is high.
- R6: After the last stored word is read, `rd_valid` goes low and `rd_data` keeps that last word until `rd_valid` rises again.
- R7: `wr_half` is high while the stored count, as seen from the write domain, is 256 or more. With reads idle it rises on the edge that stores the 256th word, and it is low once the FIFO has been drained.
- R8: While reset is held, `wr_ready`, `wr_half` and `rd_valid` are low. After `wr_rst` is released, `wr_ready` is still low after the first `wr_clk` edge and high after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Producer clock, free-running |
| wr_rst | input | 1 | Synchronous reset for the producer domain, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W (18) | Word to store |
| wr_ready | output | 1 | Room is available; registered in the producer domain |
| wr_half | output | 1 | Stored count is at least half the depth |
| rd_clk | input | 1 | Consumer clock, free-running |
| rd_rst | input | 1 | Synchronous reset for the consumer domain, active high |
| rd_en | input | 1 | Read request; consumes the word in the output register |
| rd_data | output | DATA_W (18) | Output register contents |
| rd_valid | output | 1 | A fresh word is present on `rd_data` |

## Verification
The bench builds the block at its default sizes: 18-bit words and a 9-bit address, giving 512 entries with the half-full threshold at 256. At these sizes both the half-full edge and the full edge can be hit exactly with a few hundred writes. A run of 512 writes with the reader stalled reaches the point where one more word would overflow. The producer clock runs at 8 ns and the consumer clock at 13 ns, so the pointer synchronizers see a constantly shifting phase. The vector table mixes write gaps and read gaps so that each side in turn is the faster one.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

    localparam int DEF_DATA_W = 18;
    localparam int DEF_ADDR_W = 9;

    // binary to reflected Gray code
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // reflected Gray code back to binary
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i + 1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/xclk_fifo_sync.sv
module xclk_fifo_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.s1 = d;
        s_d.s2 = s_q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign q = s_q.s2;
endmodule

// File: rtl/xclk_fifo_mem.sv
module xclk_fifo_mem #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 9
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    // entries are read only after their pointer has crossed two flops
    assign rdata = store[raddr];
endmodule

// File: rtl/xclk_fifo_wctl.sv
module xclk_fifo_wctl
    import xclk_fifo_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_req,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic              fire,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output logic              ready,
    output logic              half
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int HALF  = DEPTH / 2;

    typedef struct packed {
        logic [PW-1:0] wbin;
        logic [PW-1:0] wgray;
        logic [1:0]    arm;
        logic          ready;
        logic          half;
    } wst_t;

    wst_t          s_d, s_q;
    logic [PW-1:0] rbin;
    logic [PW-1:0] used_d;

    always_comb begin
        rbin    = PW'(from_gray(32'(rgray_sync)));
        fire    = push_req && s_q.ready;
        s_d     = s_q;
        s_d.wbin  = s_q.wbin + PW'(fire);
        s_d.wgray = PW'(to_gray(32'(s_d.wbin)));
        s_d.arm   = {s_q.arm[0], 1'b1};
        used_d    = s_d.wbin - rbin;
        s_d.ready = s_d.arm[1] && (used_d != PW'(DEPTH));
        s_d.half  = (used_d >= PW'(HALF));
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign waddr = s_q.wbin[ADDR_W-1:0];
    assign wgray = s_q.wgray;
    assign ready = s_q.ready;
    assign half  = s_q.half;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fire |-> ((s_q.wbin - rbin) != PW'(DEPTH)));  // R2
    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (push_req && !s_q.ready) |=> (s_q.wbin == $past(s_q.wbin)));  // R3
endmodule

// File: rtl/xclk_fifo_rctl.sv
module xclk_fifo_rctl
    import xclk_fifo_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pop_req,
    input  logic [ADDR_W:0]   wgray_sync,
    input  logic [DATA_W-1:0] mem_q,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic [DATA_W-1:0] dout,
    output logic              valid
);
    localparam int PW = ADDR_W + 1;

    typedef struct packed {
        logic [PW-1:0]     fbin;   // next entry to fetch into the output register
        logic [PW-1:0]     rel;    // entries handed back to the writer
        logic [PW-1:0]     rgray;
        logic [DATA_W-1:0] dout;
        logic              valid;
    } rst_t;

    rst_t          s_d, s_q;
    logic [PW-1:0] wbin;
    logic          avail;
    logic          pop;
    logic          load;

    always_comb begin
        wbin  = PW'(from_gray(32'(wgray_sync)));
        avail = (s_q.fbin != wbin);
        pop   = pop_req && s_q.valid;
        load  = avail && (!s_q.valid || pop);
        s_d   = s_q;
        s_d.rel   = s_q.rel + PW'(pop);
        s_d.rgray = PW'(to_gray(32'(s_d.rel)));
        if (load) begin
            s_d.dout  = mem_q;
            s_d.fbin  = s_q.fbin + 1'b1;
            s_d.valid = 1'b1;
        end else if (pop) begin
            s_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign raddr = s_q.fbin[ADDR_W-1:0];
    assign rgray = s_q.rgray;
    assign dout  = s_q.dout;
    assign valid = s_q.valid;

    AST_FETCH_AHEAD: assert property (@(posedge clk) disable iff (rst)
        (s_q.fbin - s_q.rel) == PW'(s_q.valid));  // R1
    AST_IGNORED_READ: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !s_q.valid) |=> (s_q.rel == $past(s_q.rel)));  // R4
    AST_HOLD_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !s_q.valid |=> (s_q.valid || $stable(s_q.dout)));  // R6
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
    import xclk_fifo_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              wr_half,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wgray, wgray_s;
    logic [PW-1:0]     rgray, rgray_s;
    logic [ADDR_W-1:0] waddr, raddr;
    logic              wfire;
    logic [DATA_W-1:0] mem_q;

    xclk_fifo_wctl #(.ADDR_W(ADDR_W)) u_wctl (
        .clk        (wr_clk),
        .rst        (wr_rst),
        .push_req   (wr_en),
        .rgray_sync (rgray_s),
        .fire       (wfire),
        .waddr      (waddr),
        .wgray      (wgray),
        .ready      (wr_ready),
        .half       (wr_half)
    );

    xclk_fifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wclk  (wr_clk),
        .we    (wfire),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (mem_q)
    );

    xclk_fifo_sync #(.W(PW)) u_w2r (
        .clk (rd_clk),
        .rst (rd_rst),
        .d   (wgray),
        .q   (wgray_s)
    );

    xclk_fifo_sync #(.W(PW)) u_r2w (
        .clk (wr_clk),
        .rst (wr_rst),
        .d   (rgray),
        .q   (rgray_s)
    );

    xclk_fifo_rctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rctl (
        .clk        (rd_clk),
        .rst        (rd_rst),
        .pop_req    (rd_en),
        .wgray_sync (wgray_s),
        .mem_q      (mem_q),
        .raddr      (raddr),
        .rgray      (rgray),
        .dout       (rd_data),
        .valid      (rd_valid)
    );
endmodule

// File: tb/xclk_fifo_tb.sv
`timescale 1ns/1ps
module xclk_fifo_tb;
    localparam int DW = 18;
    localparam int NV = 6;
    // {word count[15:6], write gap[5:3], read gap[2:0]}
    localparam logic [15:0] VEC [NV] = '{
        {10'd40,  3'd0, 3'd0},
        {10'd60,  3'd0, 3'd3},
        {10'd60,  3'd3, 3'd0},
        {10'd300, 3'd0, 3'd2},
        {10'd100, 3'd2, 3'd1},
        {10'd1,   3'd0, 3'd0}
    };

    logic          wr_clk = 0, rd_clk = 0;
    logic          wr_rst = 1, rd_rst = 1;
    logic          wr_en = 0, rd_en = 0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_ready, wr_half, rd_valid;
    logic [DW-1:0] rd_data;

    int            n_vec = 0, n_bad = 0;
    int            seq = 0;
    logic [DW-1:0] ref_q [$];
    logic [DW-1:0] last_w = '0;

    always #4   wr_clk = ~wr_clk;
    always #6.5 rd_clk = ~rd_clk;

    xclk_fifo u_dut (
        .wr_clk   (wr_clk),
        .wr_rst   (wr_rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_ready (wr_ready),
        .wr_half  (wr_half),
        .rd_clk   (rd_clk),
        .rd_rst   (rd_rst),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    function automatic logic [DW-1:0] pat(input int n);
        return DW'((n * 40503) ^ (n >> 3) ^ 32'h2A5A5);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic put_word(input logic [DW-1:0] v);
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_data = v;
        while (!wr_ready) @(negedge wr_clk);
        ref_q.push_back(v);
    endtask

    task automatic give_words(input int n, input int wgap);
        for (int k = 0; k < n; k++) begin
            for (int g = 0; g < wgap; g++) begin
                @(negedge wr_clk);
                wr_en = 1'b0;
            end
            put_word(pat(seq));
            seq++;
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic take_words(input int n, input int rgap);
        int got = 0;
        int cyc = 0;
        logic [DW-1:0] e;
        while (got < n) begin
            @(negedge rd_clk);
            rd_en = ((cyc % (rgap + 1)) == 0);
            cyc++;
            if (rd_en && rd_valid) begin
                e = (ref_q.size() > 0) ? ref_q.pop_front() : ~rd_data;
                check(rd_data == e, "R1 order", 32'(rd_data), 32'(e));
                last_w = rd_data;
                got++;
            end
        end
        @(negedge rd_clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] x;
        bit seen;

        // R8: reset state
        repeat (4) @(negedge wr_clk);
        check(!wr_ready, "R8 ready in reset", 32'(wr_ready), 0);
        check(!wr_half,  "R8 half in reset",  32'(wr_half),  0);
        check(!rd_valid, "R8 valid in reset", 32'(rd_valid), 0);
        @(negedge rd_clk) rd_rst = 1'b0;
        @(negedge wr_clk) wr_rst = 1'b0;
        @(negedge wr_clk);
        check(!wr_ready, "R8 ready after edge 1", 32'(wr_ready), 0);
        @(negedge wr_clk);
        check(wr_ready, "R8 ready after edge 2", 32'(wr_ready), 1);

        // R1: vector table, unrelated clocks, mixed gaps
        for (int i = 0; i < NV; i++) begin
            fork
                give_words(int'(VEC[i][15:6]), int'(VEC[i][5:3]));
                take_words(int'(VEC[i][15:6]), int'(VEC[i][2:0]));
            join
        end

        // R6: drained, last word held
        repeat (10) @(negedge rd_clk);
        check(!rd_valid, "R6 valid low", 32'(rd_valid), 0);
        check(rd_data == last_w, "R6 data held", 32'(rd_data), 32'(last_w));

        // R4: reads while empty are ignored
        @(negedge rd_clk) rd_en = 1'b1;
        repeat (8) @(negedge rd_clk);
        check(!rd_valid && rd_data == last_w, "R4 empty read", 32'(rd_data), 32'(last_w));
        rd_en = 1'b0;

        // R5: first word falls through with valid
        x = ~last_w;
        put_word(x);
        @(negedge wr_clk) wr_en = 1'b0;
        seen = 0;
        for (int t = 0; t < 20 && !seen; t++) begin
            @(negedge rd_clk);
            if (rd_valid) begin
                seen = 1;
                check(rd_data == x, "R5 fall-through", 32'(rd_data), 32'(x));
            end
        end
        check(seen, "R5 valid rose", 32'(seen), 1);
        void'(ref_q.pop_front());
        rd_en = 1'b1;
        @(negedge rd_clk) rd_en = 1'b0;
        last_w = x;

        // R2 / R7: fill with reader stalled
        repeat (10) @(negedge wr_clk);
        for (int i = 0; i < 512; i++) begin
            put_word(pat(seq));
            seq++;
            if (i == 254 || i == 255 || i == 510 || i == 511) begin
                @(negedge wr_clk);
                wr_en = 1'b0;
                check(wr_half == (i + 1 >= 256), "R7 half edge", 32'(wr_half), 32'(i + 1 >= 256));
                check(wr_ready == (i + 1 < 512), "R2 ready edge", 32'(wr_ready), 32'(i + 1 < 512));
            end
        end

        // R3: writes while full are dropped
        for (int i = 0; i < 6; i++) begin
            @(negedge wr_clk);
            wr_en   = 1'b1;
            wr_data = 18'h3FFFF;
        end
        check(!wr_ready, "R3 still full", 32'(wr_ready), 0);
        @(negedge wr_clk) wr_en = 1'b0;

        take_words(512, 0);
        repeat (15) @(negedge rd_clk);
        check(!rd_valid, "R3 no extra word", 32'(rd_valid), 0);
        check(ref_q.size() == 0, "R3 queue empty", 32'(ref_q.size()), 0);
        repeat (10) @(negedge wr_clk);
        check(!wr_half, "R7 half after drain", 32'(wr_half), 0);
        check(wr_ready, "R2 ready after drain", 32'(wr_ready), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule